// File: doc/BRIEF.md
# Codec Link Reset and Address Sequencer

This block sits on the controller side of a serial codec link and runs on the link bit clock. It holds the link reset line low and releases it only on request, once a minimum hold time has passed. Before the release, it keeps the bit clock running for a fixed number of cycles with reset still asserted. Every release is followed by exactly one enumeration pass. In that pass, each codec that wants an address raises its own serial-data-in (SDI) line for at least one bit-clock period. The block gathers these requests in frames of a fixed length.

At the end of the first frame that contains any request, every requesting SDI lane receives an address in the same step. Addresses are packed in ascending lane order starting at zero. If no request arrives within a set number of frames, the pass ends with an empty table.

Software can also ask for a fresh enumeration pass when the link is in a low-power state. A reset request that arrives while the release or enumeration is still running is held back until that work is finished.

Top module: `lnkseq_top`

## Requirements
- R1: After the system reset `rstN` is released, `linkRstN` is 0, `busy` is 0, `done` is 0 and every `addrValid` bit is 0.
- R2: `linkRstN` is held low for at least MIN_RST + PRE_CLKS consecutive cycles before each release. `reqExit` is remembered while the MIN_RST hold runs.
- R3: Once the hold is met and an exit request is present, `linkRstN` stays low with `busy` = 1 for exactly PRE_CLKS cycles and then goes high.
- R4: `reqEnter` while the link is idle drives `linkRstN` low on the next cycle. It also clears `done` and every `addrValid` bit.
- R5: `reqEnter` that arrives while `busy` = 1 does not touch `linkRstN`. Reset is entered one cycle after the pass completes, and `done` is high for that one cycle.
- R6: Each release of `linkRstN` starts an enumeration pass in the same cycle (`busy` = 1). No further pass starts without a new request.
- R7: SDI lanes are sampled on every rising clock edge. Frames are FRAME_LEN cycles long, counted from the first cycle of the pass. At the end of the first frame in which any lane was seen high, the table loads; on the next cycle `busy` = 0 and `done` = 1.
- R8: Lane i's address sits in `addrTable[4i+3:4i]` (ADDR_W = 4), and `addrValid[i]` marks lane i as a requester. Requesters get 0, 1, 2, … in ascending lane index. Non-requesting lanes read address 0.
- R9: All lanes that request anywhere within the same frame are served together, whether their pulses coincide or fall on different cycles.
- R10: If no lane requests within TIMEOUT_FRAMES frames, `done` rises TIMEOUT_FRAMES × FRAME_LEN cycles after the pass began, with every `addrValid` bit at 0.
- R11: `reqPower` while idle with `linkLowPower` = 1 clears the table and starts a new pass. With `linkLowPower` = 0 it has no effect.
- R12: `reqExit` outside the reset hold and `reqEnter` during the reset hold have no effect.
- R13: `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link bit clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| reqEnter | input | 1 | One-cycle request to enter link reset |
| reqExit | input | 1 | One-cycle request to leave link reset |
| reqPower | input | 1 | One-cycle power-state change request |
| linkLowPower | input | 1 | Link is currently in a low-power state |
| sdi | input | NUM_SDI | Sampled serial data in, one bit per codec lane |
| linkRstN | output | 1 | Link reset line, active low |
| addrTable | output | NUM_SDI*ADDR_W | Assigned address per lane, ADDR_W bits each |
| addrValid | output | NUM_SDI | Lane holds an assigned address |
| busy | output | 1 | Pre-release phase or enumeration pass in progress |
| done | output | 1 | Last enumeration pass has finished |

## Verification
Enumeration is driven with four request patterns, and each one separates a different fault:
- A sparse pattern (lanes 1 and 3) shows whether addresses are packed by rank or simply copied from the lane index.
- A contiguous pattern (lanes 0 to 2) exposes off-by-one errors in the rank count.
- Two lanes pulsed on different cycles of the same frame show whether a request is held until the frame ends or only seen on its own cycle.
- A pass with no pulses at all pins down the exact length of the timeout window.

Reset sequencing is tried with an early exit request, a reset request during the hold, a reset request during a pass, and power requests both with and without the low-power flag.

// File: rtl/lnkseq_pkg.sv
`timescale 1ns/1ps
package lnkseq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_PREREL = 2'd1,
    ST_INIT   = 2'd2,
    ST_IDLE   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic phaseClr;
    logic frameClr;
    logic tblClr;
    logic tblLoad;
  } seqStrobe_t;

  typedef struct packed {
    logic holdMet;
    logic preEnd;
    logic frameEnd;
    logic lastFrame;
    logic anyReq;
  } seqStatus_t;

endpackage

// File: rtl/lnkseq_datapath.sv
`timescale 1ns/1ps
module lnkseq_datapath
  import lnkseq_pkg::*;
#(
  parameter int NUM_SDI        = 4,
  parameter int ADDR_W         = 4,
  parameter int FRAME_LEN      = 256,
  parameter int MIN_RST        = 100,
  parameter int PRE_CLKS       = 25,
  parameter int TIMEOUT_FRAMES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobe,
  input  logic [NUM_SDI-1:0]        sdi,
  output seqStatus_t                status,
  output logic [NUM_SDI*ADDR_W-1:0] addrTable,
  output logic [NUM_SDI-1:0]        addrValid
);

  localparam int PH_TOP = (MIN_RST > PRE_CLKS) ? MIN_RST : PRE_CLKS;
  localparam int PH_W   = $clog2(PH_TOP + 1);
  localparam int BIT_W  = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam int FRM_W  = $clog2(TIMEOUT_FRAMES + 1);
  localparam logic [PH_W-1:0]  PH_SAT    = PH_W'(PH_TOP);
  localparam logic [PH_W-1:0]  HOLD_LAST = PH_W'(MIN_RST - 1);
  localparam logic [PH_W-1:0]  PRE_LAST  = PH_W'(PRE_CLKS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_LEN - 1);
  localparam logic [FRM_W-1:0] FRM_LAST  = FRM_W'(TIMEOUT_FRAMES - 1);

  logic [PH_W-1:0]    phaseCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [FRM_W-1:0]   frameCnt;
  logic [NUM_SDI-1:0] reqSeen;
  logic [NUM_SDI-1:0] effReq;
  logic [ADDR_W-1:0]  rank    [NUM_SDI];
  logic [ADDR_W-1:0]  laneAddr[NUM_SDI];

  // Phase counter: times the reset hold and the pre-release window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobe.phaseClr) begin
      phaseCnt <= '0;
    end else if (phaseCnt != PH_SAT) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // Frame timing for the enumeration pass.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      frameCnt <= '0;
    end else if (strobe.frameClr) begin
      bitCnt   <= '0;
      frameCnt <= '0;
    end else if (bitCnt == BIT_LAST) begin
      bitCnt   <= '0;
      frameCnt <= frameCnt + 1'b1;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // Per-frame request capture, one sticky bit per lane.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSeen <= '0;
    end else if (strobe.frameClr || (bitCnt == BIT_LAST)) begin
      reqSeen <= '0;
    end else begin
      reqSeen <= reqSeen | sdi;
    end
  end

  assign effReq = reqSeen | sdi;

  // Rank of each lane among the requesters below it.
  always_comb begin
    logic [ADDR_W-1:0] runSum;
    runSum = '0;
    for (int i = 0; i < NUM_SDI; i++) begin
      rank[i] = runSum;
      runSum  = runSum + ADDR_W'(effReq[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid <= '0;
      for (int i = 0; i < NUM_SDI; i++) laneAddr[i] <= '0;
    end else if (strobe.tblClr) begin
      addrValid <= '0;
      for (int i = 0; i < NUM_SDI; i++) laneAddr[i] <= '0;
    end else if (strobe.tblLoad) begin
      addrValid <= effReq;
      for (int i = 0; i < NUM_SDI; i++) laneAddr[i] <= effReq[i] ? rank[i] : '0;
    end
  end

  for (genvar g = 0; g < NUM_SDI; g++) begin : gLaneOut
    assign addrTable[g*ADDR_W +: ADDR_W] = laneAddr[g];
  end

  assign status.holdMet   = (phaseCnt >= HOLD_LAST);
  assign status.preEnd    = (phaseCnt == PRE_LAST);
  assign status.frameEnd  = (bitCnt == BIT_LAST);
  assign status.lastFrame = (frameCnt == FRM_LAST);
  assign status.anyReq    = |effReq;

  // R7: the table only loads at a frame boundary that carries a request.
  a_r7_load_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tblLoad |-> (status.frameEnd && status.anyReq));

  // R8: the lowest valid lane always holds address zero.
  a_r8_lane0_zero: assert property (@(posedge clk) disable iff (!rstN)
    addrValid[0] |-> (laneAddr[0] == '0));

endmodule

// File: rtl/lnkseq_ctrl.sv
`timescale 1ns/1ps
module lnkseq_ctrl
  import lnkseq_pkg::*;
#(
  parameter int MIN_RST  = 100,
  parameter int PRE_CLKS = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqEnter,
  input  logic       reqExit,
  input  logic       reqPower,
  input  logic       linkLowPower,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       linkRstN,
  output logic       busy,
  output logic       done
);

  localparam int LOW_TOP = MIN_RST + PRE_CLKS + 1;
  localparam int LOW_W   = $clog2(LOW_TOP + 1);

  seqState_t state, nextState;
  logic      exitPend;
  logic      enterPend;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_HOLD: begin
        if (status.holdMet && (exitPend || reqExit)) begin
          nextState       = ST_PREREL;
          strobe.phaseClr = 1'b1;
        end
      end
      ST_PREREL: begin
        if (status.preEnd) begin
          nextState       = ST_INIT;
          strobe.frameClr = 1'b1;
          strobe.tblClr   = 1'b1;
        end
      end
      ST_INIT: begin
        if (status.frameEnd) begin
          if (status.anyReq) begin
            strobe.tblLoad = 1'b1;
            nextState      = ST_IDLE;
          end else if (status.lastFrame) begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (reqEnter || enterPend) begin
          nextState       = ST_HOLD;
          strobe.phaseClr = 1'b1;
          strobe.tblClr   = 1'b1;
        end else if (reqPower && linkLowPower) begin
          nextState       = ST_INIT;
          strobe.frameClr = 1'b1;
          strobe.tblClr   = 1'b1;
        end
      end
      default: nextState = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HOLD;
      exitPend  <= 1'b0;
      enterPend <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_HOLD && nextState == ST_HOLD) begin
        if (reqExit) exitPend <= 1'b1;
      end else begin
        exitPend <= 1'b0;
      end
      if (nextState == ST_HOLD) begin
        enterPend <= 1'b0;
      end else if (reqEnter && (state == ST_PREREL || state == ST_INIT)) begin
        enterPend <= 1'b1;
      end
      if (state != ST_IDLE && nextState == ST_IDLE) begin
        done <= 1'b1;
      end else if (nextState != ST_IDLE) begin
        done <= 1'b0;
      end
    end
  end

  assign linkRstN = (state == ST_INIT) || (state == ST_IDLE);
  assign busy     = (state == ST_PREREL) || (state == ST_INIT);

  // Checker: consecutive low cycles of the link reset line.
  logic [LOW_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (linkRstN) begin
      lowRun <= '0;
    end else if (lowRun != LOW_W'(LOW_TOP)) begin
      lowRun <= lowRun + 1'b1;
    end
  end

  a_r2_min_low_time: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkRstN) |-> (lowRun >= LOW_W'(MIN_RST + PRE_CLKS)));

  a_r5_no_reset_in_pass: assert property (@(posedge clk) disable iff (!rstN)
    (busy && linkRstN) |=> linkRstN);

  a_r6_release_starts_pass: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkRstN) |-> busy);

  a_r13_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

endmodule

// File: rtl/lnkseq_top.sv
`timescale 1ns/1ps
module lnkseq_top
  import lnkseq_pkg::*;
#(
  parameter int NUM_SDI        = 4,
  parameter int ADDR_W         = 4,
  parameter int FRAME_LEN      = 256,
  parameter int MIN_RST        = 100,
  parameter int PRE_CLKS       = 25,
  parameter int TIMEOUT_FRAMES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqEnter,
  input  logic                      reqExit,
  input  logic                      reqPower,
  input  logic                      linkLowPower,
  input  logic [NUM_SDI-1:0]        sdi,
  output logic                      linkRstN,
  output logic [NUM_SDI*ADDR_W-1:0] addrTable,
  output logic [NUM_SDI-1:0]        addrValid,
  output logic                      busy,
  output logic                      done
);

  seqStrobe_t strobe;
  seqStatus_t status;

  lnkseq_ctrl #(
    .MIN_RST (MIN_RST),
    .PRE_CLKS(PRE_CLKS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqEnter    (reqEnter),
    .reqExit     (reqExit),
    .reqPower    (reqPower),
    .linkLowPower(linkLowPower),
    .status      (status),
    .strobe      (strobe),
    .linkRstN    (linkRstN),
    .busy        (busy),
    .done        (done)
  );

  lnkseq_datapath #(
    .NUM_SDI       (NUM_SDI),
    .ADDR_W        (ADDR_W),
    .FRAME_LEN     (FRAME_LEN),
    .MIN_RST       (MIN_RST),
    .PRE_CLKS      (PRE_CLKS),
    .TIMEOUT_FRAMES(TIMEOUT_FRAMES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sdi      (sdi),
    .status   (status),
    .addrTable(addrTable),
    .addrValid(addrValid)
  );

endmodule

// File: tb/test_lnkseq_top.sv
`timescale 1ns/1ps
module test_lnkseq_top;

  localparam int NS = 4;
  localparam int AW = 4;
  localparam int FL = 16;
  localparam int MR = 8;
  localparam int PC = 4;
  localparam int TO = 3;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqEnter = 1'b0, reqExit = 1'b0, reqPower = 1'b0, linkLowPower = 1'b0;
  logic [NS-1:0]    sdi = '0;
  logic             linkRstN, busy, done;
  logic [NS*AW-1:0] addrTable;
  logic [NS-1:0]    addrValid;

  int    nChecks = 0;
  int    nFail = 0;
  string curReq = "R1";
  bit    modelOn = 1'b0;

  always #2.5 clk = ~clk;

  lnkseq_top #(
    .NUM_SDI(NS), .ADDR_W(AW), .FRAME_LEN(FL),
    .MIN_RST(MR), .PRE_CLKS(PC), .TIMEOUT_FRAMES(TO)
  ) i_lnkseq_top (
    .clk(clk), .rstN(rstN), .reqEnter(reqEnter), .reqExit(reqExit),
    .reqPower(reqPower), .linkLowPower(linkLowPower), .sdi(sdi),
    .linkRstN(linkRstN), .addrTable(addrTable), .addrValid(addrValid),
    .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 hold, 1 pre-release, 2 pass, 3 idle.
  int               mPh, mCnt, mBit, mFrm;
  logic [NS-1:0]    mSeen, mValid;
  logic [NS*AW-1:0] mTable;
  bit               mPendE, mPendX, mDone;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mBit = 0; mFrm = 0;
      mSeen = '0; mValid = '0; mTable = '0;
      mPendE = 0; mPendX = 0; mDone = 0;
    end else begin
      logic [NS-1:0] eff;
      int r;
      eff = mSeen | sdi;
      case (mPh)
        0: begin
          if (mCnt >= MR - 1 && (mPendX || reqExit)) begin
            mPh = 1; mCnt = 0; mPendX = 0;
          end else begin
            mCnt++;
            if (reqExit) mPendX = 1;
          end
        end
        1: begin
          if (reqEnter) mPendE = 1;
          if (mCnt == PC - 1) begin
            mPh = 2; mBit = 0; mFrm = 0; mSeen = '0; mValid = '0; mTable = '0;
          end else begin
            mCnt++;
          end
        end
        2: begin
          if (reqEnter) mPendE = 1;
          if (mBit == FL - 1) begin
            if (eff != 0) begin
              r = 0;
              mTable = '0;
              for (int i = 0; i < NS; i++) begin
                if (eff[i]) begin
                  mTable[i*AW +: AW] = AW'(r);
                  r++;
                end
              end
              mValid = eff; mPh = 3; mDone = 1;
            end else if (mFrm == TO - 1) begin
              mPh = 3; mDone = 1;
            end else begin
              mFrm++; mBit = 0; mSeen = '0;
            end
          end else begin
            mBit++; mSeen = eff;
          end
        end
        default: begin
          if (reqEnter || mPendE) begin
            mPh = 0; mCnt = 0; mPendE = 0; mValid = '0; mTable = '0; mDone = 0;
          end else if (reqPower && linkLowPower) begin
            mPh = 2; mBit = 0; mFrm = 0; mSeen = '0; mValid = '0; mTable = '0; mDone = 0;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      chk(curReq, "linkRstN", 32'(linkRstN), 32'(mPh >= 2));
      chk(curReq, "busy", 32'(busy), 32'(mPh == 1 || mPh == 2));
      chk(curReq, "done", 32'(done), 32'(mDone));
      chk(curReq, "addrValid", 32'(addrValid), 32'(mValid));
      chk(curReq, "addrTable", 32'(addrTable), 32'(mTable));
      chk("R13", "busy&done", 32'(busy && done), 32'd0);
    end
  end

  // Low-time monitor for the link reset line.
  int lowSeen = 0, preSeen = 0, lowAtRise = 0, preAtRise = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      lowSeen = 0; preSeen = 0;
    end else if (!linkRstN) begin
      lowSeen++;
      if (busy) preSeen++;
    end else if (lowSeen != 0) begin
      lowAtRise = lowSeen; preAtRise = preSeen;
      lowSeen = 0; preSeen = 0;
    end
  end

  task automatic waitDone();
    int n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run();
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelOn = 1'b1;
    @(negedge clk);
    chk("R1", "linkRstN", 32'(linkRstN), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "addrValid", 32'(addrValid), 0);

    curReq = "R12";
    reqEnter = 1; @(negedge clk); reqEnter = 0;
    chk("R12", "linkRstN in hold", 32'(linkRstN), 0);
    chk("R12", "busy in hold", 32'(busy), 0);

    curReq = "R2";
    reqExit = 1; @(negedge clk); reqExit = 0;
    while (!linkRstN) @(negedge clk);
    chk("R6", "busy at release", 32'(busy), 1);
    @(negedge clk);
    chk("R2", "low cycles >= min", 32'(lowAtRise >= MR + PC), 1);
    chk("R3", "pre-release cycles", 32'(preAtRise), PC);

    curReq = "R7";
    sdi = 4'b1010; @(negedge clk); sdi = '0;
    waitDone();
    chk("R7", "done", 32'(done), 1);
    chk("R7", "busy", 32'(busy), 0);
    chk("R8", "addrValid sparse", 32'(addrValid), 32'hA);
    chk("R8", "addrTable sparse", 32'(addrTable), 32'h1000);

    curReq = "R12";
    reqExit = 1; @(negedge clk); reqExit = 0;
    repeat (3) @(negedge clk);
    chk("R12", "linkRstN after stray exit", 32'(linkRstN), 1);
    chk("R12", "done after stray exit", 32'(done), 1);
    chk("R12", "addrValid after stray exit", 32'(addrValid), 32'hA);

    curReq = "R6";
    repeat (30) @(negedge clk);
    chk("R6", "no second pass", 32'(busy), 0);

    curReq = "R4";
    reqEnter = 1; @(negedge clk); reqEnter = 0;
    chk("R4", "linkRstN", 32'(linkRstN), 0);
    chk("R4", "done", 32'(done), 0);
    chk("R4", "addrValid", 32'(addrValid), 0);

    curReq = "R10";
    reqExit = 1; @(negedge clk); reqExit = 0;
    while (!linkRstN) @(negedge clk);
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R10", "timeout cycles", 32'(n), TO * FL);
    chk("R10", "empty table", 32'(addrValid), 0);

    curReq = "R11";
    linkLowPower = 0;
    reqPower = 1; @(negedge clk); reqPower = 0;
    repeat (3) @(negedge clk);
    chk("R11", "busy without low power", 32'(busy), 0);
    chk("R11", "done without low power", 32'(done), 1);
    linkLowPower = 1;
    reqPower = 1; @(negedge clk); reqPower = 0;
    chk("R11", "busy with low power", 32'(busy), 1);
    chk("R11", "done with low power", 32'(done), 0);
    sdi = 4'b0111; @(negedge clk); sdi = '0;
    waitDone();
    chk("R8", "addrValid dense", 32'(addrValid), 32'h7);
    chk("R8", "addrTable dense", 32'(addrTable), 32'h0210);

    curReq = "R9";
    reqPower = 1; @(negedge clk); reqPower = 0;
    sdi = 4'b0100; @(negedge clk); sdi = '0;
    @(negedge clk);
    sdi = 4'b0001; @(negedge clk); sdi = '0;
    waitDone();
    chk("R9", "addrValid staggered", 32'(addrValid), 32'h5);
    chk("R9", "addrTable staggered", 32'(addrTable), 32'h0100);

    curReq = "R5";
    reqPower = 1; @(negedge clk); reqPower = 0;
    reqEnter = 1; @(negedge clk); reqEnter = 0;
    for (int k = 0; k < 5; k++) begin
      chk("R5", "linkRstN during pass", 32'(linkRstN), 1);
      @(negedge clk);
    end
    sdi = 4'b0001; @(negedge clk); sdi = '0;
    waitDone();
    chk("R5", "linkRstN at completion", 32'(linkRstN), 1);
    @(negedge clk);
    chk("R5", "deferred reset entered", 32'(linkRstN), 0);
    chk("R5", "done after deferred entry", 32'(done), 0);

    curReq = "R13";
    repeat (5) @(negedge clk);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (WATCHDOG) @(posedge clk);
        nFail++;
        $display("FAIL watchdog (all requirements): actual=%0d cycles expected=fewer", WATCHDOG);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule